// File: doc/BRIEF.md
# Programmable Multiplexed Bus Cycle Sequencer

This block runs the external side of a multiplexed address/data bus for a processor core. The core hands it one request at a time: an instruction fetch, a data read or a data write. Each request carries an address, write data and a flag that says whether the cycle needs an address-latch phase. The sequencer then produces the address-latch pulse, the fetch, read and write strobes, the address and the data-output enable. The shape of these signals comes from three timing settings. When the cycle ends it returns the read data together with a one-clock completion pulse.

All timing is counted on `clk`, which runs at twice the bus clock rate. One `clk` period is therefore half a bus clock. In this note that period is called a phase.

- The latch pulse lasts one or three phases.
- Cycles without a latch phase take their strobe length from a direct-length code.
- Cycles with a latch phase take their total length from a separate code. Their strobe gets whatever that length leaves after the latch pulse and a one-phase gap.
- An external wait input stretches the final strobe phase.
- Direct fetches can be chained into a burst. In a burst the fetch strobe never drops and the address moves on for each fetch.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held, and on the first phase after it is released, every strobe, the latch pulse, the output enable and `done_o` are low, and `req_ready` is high.
- R2: The latch pulse lasts 3 phases when `cfg_wide_latch` is 1 and 1 phase when it is 0. It starts on the phase after the request is taken.
- R3: A fetch or read without a latch phase raises its strobe on the phase after acceptance. The strobe stays high for 2*(code+1) phases, where code is `cfg_len_direct`.
- R4: A latched cycle lasts 2*(code+2) phases in total, where code is `cfg_len_latched`. This total covers the latch pulse, the gap and the strobe. The strobe gets the remainder, and never less than 1 phase.
- R5: Exactly one phase separates the fall of the latch pulse from the strobe. `addr_o` holds the request address from acceptance until the cycle completes.
- R6: Each phase in which `bus_wait` is high during the final strobe phase adds one more strobe phase. The strobe stays high throughout.
- R7: `bus_din` is sampled at the edge where a fetch or read strobe ends. On the next phase `done_o` is high for exactly one phase and `rdata_o` shows the sampled value.
- R8: In a write (`req_op` = 2'b10), `dout_oe_o` rises one phase before the write strobe and stays up for one phase after it. The write strobe length follows R3 or R4. `dout_o` carries the write data. `done_o` pulses on the phase after the hold phase.
- R9: A direct fetch (`req_op` = 2'b00, `req_latch` = 0) offered in the final phase of a fetch strobe with `bus_wait` low is taken at once. The fetch strobe stays high, `addr_o` changes to the new address, and `done_o` for the previous fetch shows on that same first phase.
- R10: `req_ready` is low during every strobe phase other than that burst window, and a request offered then is ignored. Op code 2'b01 is a read, and 2'b11 is also treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide_latch | input | 1 | 1 selects a 3-phase latch pulse, 0 selects 1 phase |
| cfg_len_latched | input | LEN_W | Total-length code for latched cycles |
| cfg_len_direct | input | LEN_W | Strobe-length code for cycles without a latch phase |
| req_valid | input | 1 | Request offered |
| req_op | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_latch | input | 1 | Request needs an address-latch phase |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request can be taken this phase |
| bus_wait | input | 1 | Stretch the active strobe |
| bus_din | input | DW | Data from the bus |
| addr_o | output | AW | Address to the bus |
| addr_latch_o | output | 1 | Address latch pulse |
| fetch_strb_o | output | 1 | Instruction fetch strobe |
| rd_strb_o | output | 1 | Data read strobe |
| wr_strb_o | output | 1 | Data write strobe |
| dout_o | output | DW | Write data to the bus |
| dout_oe_o | output | 1 | Data output enable |
| done_o | output | 1 | One-phase completion pulse |
| rdata_o | output | DW | Captured read data |

## Verification
Two things can land on the same phase, and the bench provokes both.

- **Completion and burst acceptance.** During a burst, `done_o` and read data for one fetch appear on the first phase of the next fetch. The bench offers each next fetch in the final strobe phase. On the following phase it expects `done_o`, the previous fetch's data, a still-high fetch strobe and the new address all together.
- **Wait and completion.** `bus_wait` is raised exactly in the final strobe phase, which is where completion would otherwise occur. The reference model expects the strobe to hold for as many phases as wait stays high, and the capture and `done_o` to move back by the same amount.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    OP_FETCH = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10
  } bseq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_GAP,
    ST_STRB,
    ST_HOLD
  } bseq_st_e;

endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_async) begin
          if (!rst_n_async) chain_q[g] <= 1'b0;
          else              chain_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n_async) begin
          if (!rst_n_async) chain_q[g] <= 1'b0;
          else              chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bseq_timing.sv
module bseq_timing #(
  parameter int LEN_W = 2,
  parameter int CNT_W = 4
) (
  input  logic             wide_latch,
  input  logic [LEN_W-1:0] len_latched,
  input  logic [LEN_W-1:0] len_direct,
  output logic [CNT_W-1:0] latch_ph,
  output logic [CNT_W-1:0] lat_strb_ph,
  output logic [CNT_W-1:0] dir_strb_ph
);
  localparam int TW = CNT_W + 1;

  logic [TW-1:0] total_ph;
  logic [TW-1:0] remain_ph;
  logic [TW-1:0] direct_ph;

  always_comb begin
    latch_ph  = wide_latch ? CNT_W'(3) : CNT_W'(1);
    total_ph  = TW'(2) * (TW'(len_latched) + TW'(2));
    remain_ph = total_ph - TW'(latch_ph) - TW'(1);
    // a wide latch on the shortest cycle would leave nothing: keep one phase
    lat_strb_ph = (remain_ph == '0) ? CNT_W'(1) : remain_ph[CNT_W-1:0];
    direct_ph   = TW'(2) * (TW'(len_direct) + TW'(1));
    dir_strb_ph = direct_ph[CNT_W-1:0];
  end
endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dout_o,
  output logic [DW-1:0] rdata_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdat_q, wdat_d;
  logic [DW-1:0] rdat_q, rdat_d;

  always_comb begin
    addr_d = addr_q;
    wdat_d = wdat_q;
    rdat_d = rdat_q;
    if (load_req) begin
      addr_d = req_addr;
      wdat_d = req_wdata;
    end
    if (capture) rdat_d = bus_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
    end
  end

  assign addr_o  = addr_q;
  assign dout_o  = wdat_q;
  assign rdata_o = rdat_q;
endmodule

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic             req_latch,
  input  logic             wait_i,
  input  logic [CNT_W-1:0] latch_ph,
  input  logic [CNT_W-1:0] lat_strb_ph,
  input  logic [CNT_W-1:0] dir_strb_ph,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             addr_latch,
  output logic             fetch_strb,
  output logic             rd_strb,
  output logic             wr_strb,
  output logic             dout_oe,
  output logic             done
);
  bseq_st_e         st_q, st_d;
  bseq_op_e         op_q, op_d, op_in;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             done_q, done_d;
  logic             last_ph, burst_win, burst_take, finish;

  assign op_in      = (req_op == 2'b11) ? OP_READ : bseq_op_e'(req_op);
  assign last_ph    = (st_q == ST_STRB) && (cnt_q == CNT_W'(1));
  assign burst_win  = last_ph && !wait_i && (op_q == OP_FETCH);
  assign burst_take = burst_win && req_valid && (op_in == OP_FETCH) && !req_latch;
  assign req_ready  = (st_q == ST_IDLE) || burst_win;
  assign accept     = ((st_q == ST_IDLE) && req_valid) || burst_take;
  assign capture    = last_ph && !wait_i && (op_q != OP_WRITE);
  assign finish     = capture || (st_q == ST_HOLD);

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    len_d  = len_q;
    cnt_d  = cnt_q;
    done_d = finish;
    if (cnt_q > CNT_W'(1)) cnt_d = cnt_q - CNT_W'(1);
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_d  = op_in;
          len_d = req_latch ? lat_strb_ph : dir_strb_ph;
          if (req_latch) begin
            st_d  = ST_LATCH;
            cnt_d = latch_ph;
          end else if (op_in == OP_WRITE) begin
            st_d  = ST_GAP;
            cnt_d = CNT_W'(1);
          end else begin
            st_d  = ST_STRB;
            cnt_d = dir_strb_ph;
          end
        end
      end
      ST_LATCH: begin
        if (cnt_q == CNT_W'(1)) st_d = ST_GAP;
      end
      ST_GAP: begin
        st_d  = ST_STRB;
        cnt_d = len_q;
      end
      ST_STRB: begin
        if (last_ph && !wait_i) begin
          if (op_q == OP_WRITE) begin
            st_d = ST_HOLD;
          end else if (burst_take) begin
            cnt_d = dir_strb_ph;
            len_d = dir_strb_ph;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_HOLD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_FETCH;
      cnt_q  <= '0;
      len_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      done_q <= done_d;
    end
  end

  assign addr_latch = (st_q == ST_LATCH);
  assign fetch_strb = (st_q == ST_STRB) && (op_q == OP_FETCH);
  assign rd_strb    = (st_q == ST_STRB) && (op_q == OP_READ);
  assign wr_strb    = (st_q == ST_STRB) && (op_q == OP_WRITE);
  assign dout_oe    = (op_q == OP_WRITE) &&
                      ((st_q == ST_GAP) || (st_q == ST_STRB) || (st_q == ST_HOLD));
  assign done       = done_q;

  a_r5_gap_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_latch) |-> !(fetch_strb || rd_strb || wr_strb));

  a_r6_wait_stretches: assert property (@(posedge clk) disable iff (!rst_n)
    (last_ph && wait_i) |=> ((fetch_strb || rd_strb || wr_strb) &&
                             $stable({fetch_strb, rd_strb, wr_strb})));

  a_r7_done_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_oe_before_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_strb) |-> $past(dout_oe));

  a_r8_oe_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_strb) |-> dout_oe);

  a_r9_burst_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fetch_strb) |-> $past(fetch_strb));

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_latch || dout_oe) |-> !req_ready);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide_latch,
  input  logic [LEN_W-1:0] cfg_len_latched,
  input  logic [LEN_W-1:0] cfg_len_direct,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic             req_latch,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ready,
  input  logic             bus_wait,
  input  logic [DW-1:0]    bus_din,
  output logic [AW-1:0]    addr_o,
  output logic             addr_latch_o,
  output logic             fetch_strb_o,
  output logic             rd_strb_o,
  output logic             wr_strb_o,
  output logic [DW-1:0]    dout_o,
  output logic             dout_oe_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o
);
  localparam int MAX_PH = 2 * ((1 << LEN_W) + 1);
  localparam int CNT_W  = $clog2(MAX_PH + 1);

  logic             rst_n_s;
  logic [CNT_W-1:0] latch_ph, lat_strb_ph, dir_strb_ph;
  logic             accept, capture;

  bseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_async(rst_n), .rst_n_sync(rst_n_s)
  );

  bseq_timing #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_timing (
    .wide_latch(cfg_wide_latch), .len_latched(cfg_len_latched),
    .len_direct(cfg_len_direct), .latch_ph(latch_ph),
    .lat_strb_ph(lat_strb_ph), .dir_strb_ph(dir_strb_ph)
  );

  bseq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .req_valid(req_valid), .req_op(req_op),
    .req_latch(req_latch), .wait_i(bus_wait), .latch_ph(latch_ph),
    .lat_strb_ph(lat_strb_ph), .dir_strb_ph(dir_strb_ph),
    .req_ready(req_ready), .accept(accept), .capture(capture),
    .addr_latch(addr_latch_o), .fetch_strb(fetch_strb_o), .rd_strb(rd_strb_o),
    .wr_strb(wr_strb_o), .dout_oe(dout_oe_o), .done(done_o)
  );

  bseq_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n_s), .load_req(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .capture(capture), .bus_din(bus_din),
    .addr_o(addr_o), .dout_o(dout_o), .rdata_o(rdata_o)
  );
endmodule

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wide_latch;
  logic [1:0]  cfg_len_latched, cfg_len_direct;
  logic        req_valid, req_latch;
  logic [1:0]  req_op;
  logic [15:0] req_addr, req_wdata;
  logic        req_ready;
  logic        bus_wait;
  logic [15:0] bus_din;
  logic [15:0] addr_o, dout_o, rdata_o;
  logic        addr_latch_o, fetch_strb_o, rd_strb_o, wr_strb_o, dout_oe_o, done_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  bus_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide_latch(cfg_wide_latch),
    .cfg_len_latched(cfg_len_latched), .cfg_len_direct(cfg_len_direct),
    .req_valid(req_valid), .req_op(req_op), .req_latch(req_latch),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .bus_wait(bus_wait), .bus_din(bus_din), .addr_o(addr_o),
    .addr_latch_o(addr_latch_o), .fetch_strb_o(fetch_strb_o),
    .rd_strb_o(rd_strb_o), .wr_strb_o(wr_strb_o), .dout_o(dout_o),
    .dout_oe_o(dout_oe_o), .done_o(done_o), .rdata_o(rdata_o)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // order: latch, fetch, read, write, oe, done
  task automatic expect_bus(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {addr_latch_o, fetch_strb_o, rd_strb_o, wr_strb_o, dout_oe_o, done_o};
    chk(act === exp, tag, int'(act), int'(exp));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] din_of(input logic [15:0] a);
    return a ^ 16'h5a3c;
  endfunction

  task automatic run_cycle(input string tag, input int op, input bit lat,
                           input logic [15:0] addr, input logic [15:0] wd,
                           input bit wide, input int lcode, input int dcode,
                           input int waitn, input bit nuis);
    int  lp, sp;
    bit  is_wr;
    logic [5:0] sv;
    is_wr = (op == 2);
    lp = wide ? 3 : 1;
    if (lat) begin
      sp = 2 * (lcode + 2) - lp - 1;
      if (sp < 1) sp = 1;
    end else begin
      sp = 2 * (dcode + 1);
    end
    sv = (op == 0) ? 6'b010000 : (is_wr ? 6'b000110 : 6'b001000);
    cfg_wide_latch  = wide;
    cfg_len_latched = 2'(lcode);
    cfg_len_direct  = 2'(dcode);
    req_op = 2'(op); req_latch = lat; req_addr = addr; req_wdata = wd;
    bus_din = din_of(addr);
    req_valid = 1'b1;
    chk(req_ready === 1'b1, "R10 ready when idle", int'(req_ready), 1);
    step();
    req_valid = 1'b0;
    if (nuis) begin
      req_valid = 1'b1; req_op = 2'b10; req_latch = 1'b1; req_addr = 16'hffff;
    end
    if (lat) begin
      for (int i = 0; i < lp; i++) begin
        expect_bus({tag, " R2 latch"}, 6'b100000);
        chk(addr_o === addr, "R5 addr during latch", int'(addr_o), int'(addr));
        step();
      end
    end
    if (lat || is_wr) begin
      expect_bus({tag, " R5 gap"}, is_wr ? 6'b000010 : 6'b000000);
      chk(addr_o === addr, "R5 addr in gap", int'(addr_o), int'(addr));
      step();
    end
    for (int i = 0; i < sp + waitn; i++) begin
      expect_bus({tag, (i >= sp) ? " R6 stretch" : " strobe"}, sv);
      chk(addr_o === addr, "R5 addr in strobe", int'(addr_o), int'(addr));
      if (is_wr) chk(dout_o === wd, "R8 write data", int'(dout_o), int'(wd));
      if (nuis && i < sp - 1)
        chk(req_ready === 1'b0, "R10 busy not ready", int'(req_ready), 0);
      if (i >= sp - 1) req_valid = 1'b0;
      bus_wait = (i >= sp - 1) && (i < sp - 1 + waitn);
      step();
    end
    bus_wait = 1'b0;
    if (is_wr) begin
      expect_bus({tag, " R8 hold"}, 6'b000010);
      step();
    end
    expect_bus({tag, " R7 done"}, 6'b000001);
    if (!is_wr)
      chk(rdata_o === din_of(addr), "R7 read data", int'(rdata_o), int'(din_of(addr)));
    chk(addr_o === addr, "R10 nuisance ignored", int'(addr_o), int'(addr));
  endtask

  task automatic run_burst(input logic [15:0] a0, input int n, input int dcode);
    int sp;
    logic [15:0] a;
    sp = 2 * (dcode + 1);
    cfg_len_direct = 2'(dcode);
    req_op = 2'b00; req_latch = 1'b0; req_addr = a0; bus_din = din_of(a0);
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      a = a0 + 16'(2 * k);
      for (int i = 0; i < sp; i++) begin
        req_valid = 1'b0;
        expect_bus("R9 burst strobe", (k > 0 && i == 0) ? 6'b010001 : 6'b010000);
        chk(addr_o === a, "R9 burst address", int'(addr_o), int'(a));
        if (k > 0 && i == 0) begin
          chk(rdata_o === din_of(a - 16'd2), "R9 burst data",
              int'(rdata_o), int'(din_of(a - 16'd2)));
          bus_din = din_of(a);
        end
        if (i == sp - 1 && k < n - 1) begin
          chk(req_ready === 1'b1, "R9 burst window ready", int'(req_ready), 1);
          req_addr = a + 16'd2;
          req_valid = 1'b1;
        end
        step();
      end
    end
    req_valid = 1'b0;
    expect_bus("R9 burst done", 6'b000001);
    chk(rdata_o === din_of(a), "R9 last data", int'(rdata_o), int'(din_of(a)));
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_wide_latch = 1'b0; cfg_len_latched = '0; cfg_len_direct = '0;
    req_valid = 1'b0; req_op = '0; req_latch = 1'b0;
    req_addr = '0; req_wdata = '0; bus_wait = 1'b0; bus_din = '0;
    repeat (3) step();
    expect_bus("R1 in reset", 6'b000000);
    rst_n = 1'b1;
    step();
    expect_bus("R1 after release", 6'b000000);
    chk(req_ready === 1'b1, "R1 ready", int'(req_ready), 1);
    repeat (3) step();

    for (int c = 0; c < 4; c++)
      run_cycle("R3 direct fetch", 0, 1'b0, 16'(16'h1000 + c), 16'h0, 1'b0, 0, c, 0, 1'b0);
    for (int c = 0; c < 4; c++)
      run_cycle("R4 narrow read", 1, 1'b1, 16'(16'h2200 + c), 16'h0, 1'b0, c, 0, 0, 1'b0);
    for (int c = 0; c < 4; c++)
      run_cycle("R4 wide fetch", 0, 1'b1, 16'(16'h3300 + c), 16'h0, 1'b1, c, 0, 0, 1'b0);
    run_cycle("R3 direct read op3", 3, 1'b0, 16'h4444, 16'h0, 1'b0, 0, 1, 0, 1'b0);
    run_cycle("R6 wait direct read", 1, 1'b0, 16'h5555, 16'h0, 1'b0, 0, 1, 3, 1'b0);
    run_cycle("R6 wait latched fetch", 0, 1'b1, 16'h5656, 16'h0, 1'b1, 2, 0, 1, 1'b0);
    run_cycle("R8 latched write", 2, 1'b1, 16'h6600, 16'hbeef, 1'b0, 1, 0, 0, 1'b0);
    run_cycle("R8 direct write", 2, 1'b0, 16'h6602, 16'hcafe, 1'b0, 0, 2, 2, 1'b0);
    run_cycle("R8 wide write", 2, 1'b1, 16'h6604, 16'h1234, 1'b1, 0, 0, 0, 1'b0);
    run_cycle("R10 nuisance read", 1, 1'b1, 16'h7700, 16'h0, 1'b0, 3, 0, 0, 1'b1);
    run_cycle("R10 nuisance fetch", 0, 1'b0, 16'h7702, 16'h0, 1'b0, 0, 3, 0, 1'b1);
    step();
    run_burst(16'h8000, 4, 1);
    step();
    run_burst(16'h9000, 3, 0);
    step();
    expect_bus("R7 idle after done", 6'b000000);
    summary();
  end
endmodule